// File: doc/BRIEF.md
# Pixel Format Packer

This block takes a stream of 32-bit ARGB pixels, with 8 bits for each channel, and turns each one into the byte layout that a chosen storage format needs. A 4-bit format code picks that layout. The block reorders the channels and, for the 16-bit formats, keeps only the upper bits of each channel. It also decides whether the alpha byte holds the pixel's own alpha, that alpha inverted, or a fixed fill value.

The packed bytes go into a word accumulator, so several pixels share one 32-bit output word. Each 16-bit pixel takes two bytes and each 24-bit pixel takes three, and a 24-bit pixel may straddle two words. Every output word carries a per-lane byte strobe. A 4-bit lane mask gates the strobe of each lane. When the last pixel of a line is accepted, any partly filled word is flushed, and only its filled lanes are strobed. Format codes that have no layout write nothing and raise a one-cycle error pulse.

Pixels come in on a valid/ready handshake. Words leave on a valid/ready handshake through a single output register.

Top module: `pxp_packer`

## Requirements
- R1: Codes 0..3 are 16-bit formats with 4 bits per channel, taken from the top nibble of each channel. From the highest nibble (bits 15:12) down to bits 3:0, the channel order is A,B,G,R for code 0, A,R,G,B for code 1, B,G,R,A for code 2 and R,G,B,A for code 3.
- R2: Code 6 stores {B[7:3],G[7:2],R[7:3]} and code 7 stores {R[7:3],G[7:2],B[7:3]}, both in 16 bits. Two 16-bit pixels fill one word, with the first pixel in bits 15:0.
- R3: Code 8 stores the 24-bit value {B,G,R} and code 9 stores {R,G,B}. Bytes are placed in the word stream least significant byte first, so four such pixels fill exactly three words.
- R4: Codes 12..15 store a full 32-bit word per pixel. From byte 3 down to byte 0 the channel order is A,B,G,R for code 12, A,R,G,B for code 13, B,G,R,A for code 14 and R,G,B,A for code 15.
- R5: With alpha enable set, the stored alpha is the pixel alpha (in_pixel[31:24]). It is bitwise inverted when the invert input is 1.
- R6: With alpha enable clear, the stored alpha is all ones when the invert input is 0 and all zeros when it is 1.
- R7: out_strb[i] is 1 only when lane i (bits 8i+7:8i) holds a valid byte and in_byte_en[i] is 1. The lane data is present whether or not the mask allows it.
- R8: A pixel with in_eol set flushes a partly filled word. Only the filled lanes are strobed, the unfilled lanes read zero, and the next pixel starts again at lane 0.
- R9: Codes 4, 5, 10 and 11 add no bytes. Accepting such a pixel drives out_err high for exactly the next cycle.
- R10: While out_valid is 1 and out_ready is 0, out_data and out_strb hold and in_ready is 0.
- R11: After reset, out_valid and out_err are 0 and in_ready is 1.
- R12: If an end-of-line pixel overflows one full word, the full word is emitted first. The leftover bytes come out as a second word, and in_ready stays 0 until that second word has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel present |
| in_ready | output | 1 | Pixel accepted this cycle when in_valid is high |
| in_pixel | input | 32 | A[31:24] R[23:16] G[15:8] B[7:0] |
| in_eol | input | 1 | Last pixel of the line; flush afterwards |
| in_fmt | input | 4 | Storage format code |
| in_alpha_en | input | 1 | Store pixel alpha instead of the fill value |
| in_alpha_inv | input | 1 | Invert stored alpha, or select the zero fill |
| in_byte_en | input | 4 | Lane mask applied to strobes |
| out_valid | output | 1 | Packed word present |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 32 | Packed word, lane i in bits 8i+7:8i |
| out_strb | output | 4 | Byte strobes per lane |
| out_err | output | 1 | One-cycle pulse after an unsupported code is accepted |

## Verification
If the fill counter is off, the error shows on the next emitted word: bytes land in the wrong lanes, or a word appears after the wrong number of pixels. The three-word 24-bit sequence and the straddling end-of-line case expose this within one line. If the flush-pending flag is wrong, the port shows either a missing tail word or in_ready held low for a cycle too few or too many. If the output register loses its hold, out_data changes during a stall in the very next cycle.

// File: rtl/pxp_pkg.sv
package pxp_pkg;

    localparam int CH_W      = 8;
    localparam int FMT_W     = 4;
    localparam int PIX_BYTES = 4;

    // Arrange four channel bytes by a 2-bit order selector, high byte first.
    function automatic logic [4*CH_W-1:0] order4(
        input logic [1:0]      sel,
        input logic [CH_W-1:0] a,
        input logic [CH_W-1:0] r,
        input logic [CH_W-1:0] g,
        input logic [CH_W-1:0] b
    );
        logic [4*CH_W-1:0] res;
        case (sel)
            2'd0:    res = {a, b, g, r};
            2'd1:    res = {a, r, g, b};
            2'd2:    res = {b, g, r, a};
            default: res = {r, g, b, a};
        endcase
        return res;
    endfunction

endpackage

// File: rtl/pxp_alpha.sv
module pxp_alpha
    import pxp_pkg::*;
(
    input  logic [CH_W-1:0] alpha_in,
    input  logic            use_pixel,
    input  logic            invert,
    output logic [CH_W-1:0] alpha_out
);

    always_comb begin
        if (use_pixel) begin
            alpha_out = invert ? ~alpha_in : alpha_in;
        end else begin
            alpha_out = {CH_W{~invert}};
        end
    end

endmodule

// File: rtl/pxp_format.sv
module pxp_format
    import pxp_pkg::*;
(
    input  logic [FMT_W-1:0]          code,
    input  logic [CH_W-1:0]           a_val,
    input  logic [CH_W-1:0]           r_in,
    input  logic [CH_W-1:0]           g_in,
    input  logic [CH_W-1:0]           b_in,
    output logic [PIX_BYTES*CH_W-1:0] packed_px,
    output logic [2:0]                nbytes,
    output logic                      bad
);

    localparam int NIB = CH_W / 2;

    logic [4*CH_W-1:0] wide;
    logic [4*CH_W-1:0] narrow;

    always_comb begin
        wide   = order4(code[1:0], a_val, r_in, g_in, b_in);
        narrow = order4(code[1:0],
                        {{NIB{1'b0}}, a_val[CH_W-1 -: NIB]},
                        {{NIB{1'b0}}, r_in[CH_W-1 -: NIB]},
                        {{NIB{1'b0}}, g_in[CH_W-1 -: NIB]},
                        {{NIB{1'b0}}, b_in[CH_W-1 -: NIB]});
        packed_px = '0;
        nbytes    = 3'd0;
        bad       = 1'b0;
        case (code)
            4'd0, 4'd1, 4'd2, 4'd3: begin
                for (int j = 0; j < 4; j++) begin
                    packed_px[j*NIB +: NIB] = narrow[j*CH_W +: NIB];
                end
                nbytes = 3'd2;
            end
            4'd6: begin
                packed_px[15:0] = {b_in[7:3], g_in[7:2], r_in[7:3]};
                nbytes          = 3'd2;
            end
            4'd7: begin
                packed_px[15:0] = {r_in[7:3], g_in[7:2], b_in[7:3]};
                nbytes          = 3'd2;
            end
            4'd8: begin
                packed_px[23:0] = {b_in, g_in, r_in};
                nbytes          = 3'd3;
            end
            4'd9: begin
                packed_px[23:0] = {r_in, g_in, b_in};
                nbytes          = 3'd3;
            end
            4'd12, 4'd13, 4'd14, 4'd15: begin
                packed_px = wide;
                nbytes    = 3'd4;
            end
            default: begin
                bad = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/pxp_lanes.sv
module pxp_lanes
    import pxp_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CNT_W = 3
) (
    input  logic [LANES*CH_W-1:0]     acc,
    input  logic [CNT_W-1:0]          fill,
    input  logic [PIX_BYTES*CH_W-1:0] px,
    input  logic [2:0]                nbytes,
    output logic [2*LANES*CH_W-1:0]   cdat,
    output logic [2*LANES-1:0]        cvld
);

    localparam int SEL_W = $clog2(PIX_BYTES);

    for (genvar p = 0; p < 2*LANES; p++) begin : g_pos
        logic [CNT_W-1:0] k;
        always_comb begin
            k = CNT_W'(p) - fill;
            cdat[p*CH_W +: CH_W] = '0;
            cvld[p]              = 1'b0;
            if (CNT_W'(p) < fill) begin
                if (p < LANES) begin
                    cdat[p*CH_W +: CH_W] = acc[(p % LANES)*CH_W +: CH_W];
                    cvld[p]              = 1'b1;
                end
            end else if (k < CNT_W'(nbytes)) begin
                cdat[p*CH_W +: CH_W] = px[CH_W*k[SEL_W-1:0] +: CH_W];
                cvld[p]              = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pxp_packer.sv
module pxp_packer
    import pxp_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [4*CH_W-1:0]     in_pixel,
    input  logic                  in_eol,
    input  logic [FMT_W-1:0]      in_fmt,
    input  logic                  in_alpha_en,
    input  logic                  in_alpha_inv,
    input  logic [LANES-1:0]      in_byte_en,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [LANES*CH_W-1:0] out_data,
    output logic [LANES-1:0]      out_strb,
    output logic                  out_err
);

    localparam int CNT_W  = $clog2(2*LANES);
    localparam int WORD_W = LANES*CH_W;

    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic [CNT_W-1:0]  fill;
        logic              flush;
        logic [LANES-1:0]  mask;
        logic              ov;
        logic [WORD_W-1:0] od;
        logic [LANES-1:0]  os;
        logic              err;
    } pk_state_t;

    pk_state_t s_d, s_q;

    logic [CH_W-1:0]           alpha_v;
    logic [PIX_BYTES*CH_W-1:0] px_packed;
    logic [2:0]                px_n;
    logic                      px_bad;
    logic [2*WORD_W-1:0]       c_dat;
    logic [2*LANES-1:0]        c_vld;
    logic [LANES-1:0]          acc_vld;
    logic                      slot_free;
    logic                      take;
    logic [CNT_W-1:0]          total;

    pxp_alpha u_alpha (
        .alpha_in  (in_pixel[31:24]),
        .use_pixel (in_alpha_en),
        .invert    (in_alpha_inv),
        .alpha_out (alpha_v)
    );

    pxp_format u_format (
        .code      (in_fmt),
        .a_val     (alpha_v),
        .r_in      (in_pixel[23:16]),
        .g_in      (in_pixel[15:8]),
        .b_in      (in_pixel[7:0]),
        .packed_px (px_packed),
        .nbytes    (px_n),
        .bad       (px_bad)
    );

    pxp_lanes #(.LANES(LANES), .CNT_W(CNT_W)) u_lanes (
        .acc    (s_q.acc),
        .fill   (s_q.fill),
        .px     (px_packed),
        .nbytes (px_n),
        .cdat   (c_dat),
        .cvld   (c_vld)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_accv
        assign acc_vld[i] = CNT_W'(i) < s_q.fill;
    end

    always_comb begin
        slot_free = !s_q.ov || out_ready;
        in_ready  = !s_q.flush && slot_free;
        take      = in_valid && in_ready;
        total     = s_q.fill + CNT_W'(px_n);

        s_d     = s_q;
        s_d.err = take && px_bad;
        if (out_ready) begin
            s_d.ov = 1'b0;
            s_d.os = '0;
        end

        if (s_q.flush && slot_free) begin
            s_d.ov    = 1'b1;
            s_d.od    = s_q.acc;
            s_d.os    = acc_vld & s_q.mask;
            s_d.acc   = '0;
            s_d.fill  = '0;
            s_d.flush = 1'b0;
        end else if (take) begin
            s_d.mask = in_byte_en;
            if (total >= CNT_W'(LANES)) begin
                s_d.ov    = 1'b1;
                s_d.od    = c_dat[WORD_W-1:0];
                s_d.os    = in_byte_en;
                s_d.acc   = c_dat[2*WORD_W-1:WORD_W];
                s_d.fill  = total - CNT_W'(LANES);
                s_d.flush = in_eol && (|c_vld[2*LANES-1:LANES]);
            end else if (in_eol) begin
                if (total != '0) begin
                    s_d.ov = 1'b1;
                    s_d.od = c_dat[WORD_W-1:0];
                    s_d.os = c_vld[LANES-1:0] & in_byte_en;
                end
                s_d.acc  = '0;
                s_d.fill = '0;
            end else begin
                s_d.acc  = c_dat[WORD_W-1:0];
                s_d.fill = total;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.ov;
    assign out_data  = s_q.od;
    assign out_strb  = s_q.os;
    assign out_err   = s_q.err;

    // Stalled output word must not move.
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_strb));

    assert_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    // Error pulse only after acceptance of a code with no layout.
    assert_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> $past(in_valid && in_ready &&
            ((in_fmt[3:2] == 2'b01 && !in_fmt[1]) || (in_fmt[3:2] == 2'b10 && in_fmt[1]))));

    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_strb == '0);

    // Pending tail word leaves as soon as the output drains.
    assert_tail_R12: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.flush && out_ready |=> out_valid && !s_q.flush);

    assert_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fill < CNT_W'(LANES));

endmodule

// File: tb/pxp_packer_test.sv
`timescale 1ns/1ps
module pxp_packer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_pixel = '0;
    logic        in_eol = 1'b0;
    logic [3:0]  in_fmt = '0;
    logic        in_alpha_en = 1'b0;
    logic        in_alpha_inv = 1'b0;
    logic [3:0]  in_byte_en = 4'hF;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic [3:0]  out_strb;
    logic        out_err;

    always #10 clk = ~clk;

    pxp_packer uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_pixel(in_pixel), .in_eol(in_eol), .in_fmt(in_fmt),
        .in_alpha_en(in_alpha_en), .in_alpha_inv(in_alpha_inv),
        .in_byte_en(in_byte_en), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_strb(out_strb), .out_err(out_err)
    );

    int total = 0;
    int bad = 0;
    int nword = 0;
    int rd = 0;
    int nerr = 0;
    logic [31:0] gd [64];
    logic [3:0]  gs [64];

    // {fmt, alpha_en, alpha_inv, pixel, expected data, expected strobe}
    localparam int NV = 15;
    localparam logic [73:0] VEC [NV] = '{
        {4'd0,  1'b1, 1'b0, 32'hC35A962F, 32'h0000C295, 4'h3},
        {4'd1,  1'b1, 1'b0, 32'hC35A962F, 32'h0000C592, 4'h3},
        {4'd2,  1'b1, 1'b0, 32'hC35A962F, 32'h0000295C, 4'h3},
        {4'd3,  1'b1, 1'b0, 32'hC35A962F, 32'h0000592C, 4'h3},
        {4'd1,  1'b0, 1'b0, 32'hC35A962F, 32'h0000F592, 4'h3},
        {4'd6,  1'b1, 1'b0, 32'hC35A962F, 32'h00002CAB, 4'h3},
        {4'd7,  1'b1, 1'b0, 32'hC35A962F, 32'h00005CA5, 4'h3},
        {4'd8,  1'b1, 1'b0, 32'hC35A962F, 32'h002F965A, 4'h7},
        {4'd9,  1'b1, 1'b0, 32'hC35A962F, 32'h005A962F, 4'h7},
        {4'd12, 1'b1, 1'b0, 32'hC35A962F, 32'hC32F965A, 4'hF},
        {4'd13, 1'b1, 1'b0, 32'hC35A962F, 32'hC35A962F, 4'hF},
        {4'd14, 1'b1, 1'b0, 32'hC35A962F, 32'h2F965AC3, 4'hF},
        {4'd15, 1'b1, 1'b0, 32'hC35A962F, 32'h5A962FC3, 4'hF},
        {4'd13, 1'b1, 1'b1, 32'hC35A962F, 32'h3C5A962F, 4'hF},
        {4'd13, 1'b0, 1'b1, 32'hC35A962F, 32'h005A962F, 4'hF}
    };

    // Output monitor: a word is recorded on the cycle it is handed over.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                if (out_valid && out_ready && nword < 64) begin
                    gd[nword] = out_data;
                    gs[nword] = out_strb;
                    nword++;
                end
                if (out_err) nerr++;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] px, input logic [3:0] f, input logic ae,
                        input logic ai, input logic [3:0] be, input logic eol);
        @(negedge clk);
        in_valid = 1'b1; in_pixel = px; in_fmt = f; in_alpha_en = ae;
        in_alpha_inv = ai; in_byte_en = be; in_eol = eol;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_eol = 1'b0;
    endtask

    task automatic take(input string tag, input logic [31:0] ed, input logic [3:0] es);
        wait (rd < nword);
        chk({tag, " data"}, gd[rd], ed);
        chk({tag, " strb"}, {28'h0, gs[rd]}, {28'h0, es});
        rd++;
    endtask

    task automatic finish_run;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(20 * 50000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R11 out_valid", {31'h0, out_valid}, 32'h0);
        chk("R11 out_err", {31'h0, out_err}, 32'h0);
        chk("R11 in_ready", {31'h0, in_ready}, 32'h1);

        // Table walk: one end-of-line pixel per vector (R1 R2 R3 R4 R5 R6 R8).
        for (int i = 0; i < NV; i++) begin
            send(VEC[i][67:36], VEC[i][73:70], VEC[i][69], VEC[i][68], 4'hF, 1'b1);
            take($sformatf("R1-table vec%0d R4 R5 R6 R8", i), VEC[i][35:4], VEC[i][3:0]);
        end

        // R2 two 16-bit pixels share a word, first in the low half.
        send(32'hC35A962F, 4'd1, 1'b1, 1'b0, 4'hF, 1'b0);
        send(32'h11223344, 4'd1, 1'b1, 1'b0, 4'hF, 1'b1);
        take("R2 pair", 32'h1234C592, 4'hF);

        // R3 four 24-bit pixels fill three words.
        send(32'hFF112233, 4'd9, 1'b1, 1'b0, 4'hF, 1'b0);
        send(32'hFF445566, 4'd9, 1'b1, 1'b0, 4'hF, 1'b0);
        send(32'hFF778899, 4'd9, 1'b1, 1'b0, 4'hF, 1'b0);
        send(32'hFFAABBCC, 4'd9, 1'b1, 1'b0, 4'hF, 1'b1);
        take("R3 w0", 32'h66112233, 4'hF);
        take("R3 w1", 32'h88994455, 4'hF);
        take("R3 w2", 32'hAABBCC77, 4'hF);

        // R12 end of line in the middle of a straddling pixel.
        send(32'hFF112233, 4'd9, 1'b1, 1'b0, 4'hF, 1'b0);
        send(32'hFF445566, 4'd9, 1'b1, 1'b0, 4'hF, 1'b0);
        send(32'hFF778899, 4'd9, 1'b1, 1'b0, 4'hF, 1'b1);
        chk("R12 in_ready low with tail pending", {31'h0, in_ready}, 32'h0);
        take("R12 w0", 32'h66112233, 4'hF);
        take("R12 w1", 32'h88994455, 4'hF);
        take("R12 tail R8", 32'h00000077, 4'h1);

        // R7 lane mask gates strobes only.
        send(32'hC35A962F, 4'd13, 1'b1, 1'b0, 4'h5, 1'b1);
        take("R7 mask", 32'hC35A962F, 4'h5);

        // R9 unsupported code alone: no word, one error pulse.
        send(32'h12345678, 4'd5, 1'b1, 1'b0, 4'hF, 1'b1);
        repeat (4) @(negedge clk);
        #1;
        chk("R9 no word", nword, rd);
        chk("R9 err pulses", nerr, 1);

        // R9 unsupported code between two pixels leaves packing intact.
        send(32'hC35A962F, 4'd1, 1'b1, 1'b0, 4'hF, 1'b0);
        send(32'hDEADBEEF, 4'd10, 1'b1, 1'b0, 4'hF, 1'b0);
        send(32'h11223344, 4'd1, 1'b1, 1'b0, 4'hF, 1'b1);
        take("R9 packing", 32'h1234C592, 4'hF);
        chk("R9 err pulses second", nerr, 2);

        // R10 stall: word holds, input blocked.
        @(negedge clk);
        out_ready = 1'b0;
        send(32'hC35A962F, 4'd15, 1'b1, 1'b0, 4'hF, 1'b1);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            #1;
            chk("R10 valid held", {31'h0, out_valid}, 32'h1);
            chk("R10 data held", out_data, 32'h5A962FC3);
            chk("R10 in_ready low", {31'h0, in_ready}, 32'h0);
        end
        @(negedge clk);
        out_ready = 1'b1;
        take("R10 released", 32'h5A962FC3, 4'hF);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule